// File: doc/BRIEF.md
# Seven-Pin Bidirectional GPIO Port

This block is a small general-purpose I/O port with seven pins, attached to a byte-wide register bus in an I/O address space. Software sees three locations. The first is a data latch. The second is a direction register that chooses, for each pin, whether the pad driver is enabled. The third is a read-only window onto the levels actually present at the pins.

When a pin is an output, it drives the value held in its latch bit. When a pin is an input, its driver is off, and the same latch bit instead turns on a weak pull-up. A read of the latch location returns what software stored. A read of the pin location returns the pad level after a two-flop synchronizer, so it reflects both external drivers and the port's own drive.

The reset input is asynchronous and active low. When asserted, it turns off every pad driver at once, without waiting for a clock edge. Its release is synchronised internally before the registers leave reset.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted, and after it is released until the first write, the latch and direction locations read 0x00, and all output-enable, output-value and pull-up signals are 0.
- R2: A write to address 0x12 stores write-data bits 6..0 in the data latch on the clock edge where write-enable is high. A read of 0x12 returns the latch with bit 7 as 0.
- R3: A write to address 0x11 stores write-data bits 6..0 in the direction register. A read of 0x11 returns it with bit 7 as 0.
- R4: A write to the pin-read address 0x10 changes neither the latch nor the direction register.
- R5: A pin whose direction bit is 1 has its output enable at 1, its output value equal to its latch bit, and its pull-up at 0.
- R6: A pin whose direction bit is 0 has its output enable at 0 and its output value at 0. Its pull-up equals its latch bit, so clearing the latch bit or making the pin an output turns the pull-up off.
- R7: A read of 0x10 returns the pin input levels in bits 6..0, and 0 in bit 7. The value is delayed by two clock edges through a synchronizer.
- R8: A read of any address other than 0x10, 0x11 and 0x12 returns 0x00. A write to such an address changes no state.
- R9: Asserting reset clears all output enables immediately, with no clock edge in between.
- R10: Read data follows the address combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 6 | I/O-space register address |
| io_we | input | 1 | Write enable, sampled on the rising clock edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Combinational read data for io_addr |
| pin_out | output | 7 | Per-pin output value to the pad driver |
| pin_oe | output | 7 | Per-pin output enable of the pad driver |
| pin_pu | output | 7 | Per-pin weak pull-up enable |
| pin_in | input | 7 | Per-pin level sensed at the pad |

## Verification
The latch and direction registers are loaded with mixed patterns: all ones, complementary nibbles, alternating bits and an isolated bit 7. In these patterns output pins and pulled-up input pins sit side by side, so a pull-up that leaks onto an output pin, or a drive value that leaks onto an input pin, shows up on a neighbouring bit. Writes aimed at the pin-read address and at unmapped addresses are followed by readback, which separates a correctly read-only decode from one that aliases onto a real register. A modelled pad that resolves driver, pull-up and external source shows three things: a floating pulled-up pin reads high, a driven pin reads its latch value, and the pin read lags by exactly two edges.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int GPIO_PINS       = 7;
  localparam int GPIO_ADDR_W     = 6;
  localparam int GPIO_DATA_W     = 8;
  localparam int GPIO_SYNC_DEPTH = 2;

  localparam logic [GPIO_ADDR_W-1:0] GPIO_PIN_ADDR   = 6'h10;
  localparam logic [GPIO_ADDR_W-1:0] GPIO_DIR_ADDR   = 6'h11;
  localparam logic [GPIO_ADDR_W-1:0] GPIO_LATCH_ADDR = 6'h12;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_PIN   = 2'd1,
    SEL_DIR   = 2'd2,
    SEL_LATCH = 2'd3
  } gpio_sel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_pkg::*;
#(
  parameter int                 ADDR_W     = GPIO_ADDR_W,
  parameter logic [ADDR_W-1:0]  PIN_ADDR   = GPIO_PIN_ADDR,
  parameter logic [ADDR_W-1:0]  DIR_ADDR   = GPIO_DIR_ADDR,
  parameter logic [ADDR_W-1:0]  LATCH_ADDR = GPIO_LATCH_ADDR
) (
  input  logic [ADDR_W-1:0] addr,
  output gpio_sel_e         sel
);
  always_comb begin
    if      (addr == LATCH_ADDR) sel = SEL_LATCH;
    else if (addr == DIR_ADDR)   sel = SEL_DIR;
    else if (addr == PIN_ADDR)   sel = SEL_PIN;
    else                         sel = SEL_NONE;
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int PINS = GPIO_PINS
) (
  input  logic            clk,
  input  logic            rst_sync_n,
  input  logic            we,
  input  gpio_sel_e       sel,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] latch_q,
  output logic [PINS-1:0] dir_q
);
  logic            latch_en;
  logic            dir_en;
  logic [PINS-1:0] latch_d;
  logic [PINS-1:0] dir_d;

  always_comb begin
    latch_en = we && (sel == SEL_LATCH);
    dir_en   = we && (sel == SEL_DIR);
    latch_d  = latch_en ? wdata : latch_q;
    dir_d    = dir_en   ? wdata : dir_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      latch_q <= latch_d;
      dir_q   <= dir_d;
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int PINS   = 7,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_sync_n,
  input  logic [PINS-1:0] pin_raw,
  output logic [PINS-1:0] pin_sync
);
  genvar g;
  generate
    for (g = 0; g < PINS; g++) begin : g_bit
      logic [STAGES-1:0] stage_q;
      logic [STAGES-1:0] stage_d;
      always_comb begin
        stage_d = {stage_q[STAGES-2:0], pin_raw[g]};
      end
      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n) stage_q <= '0;
        else             stage_q <= stage_d;
      end
      assign pin_sync[g] = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int PINS = 7
) (
  input  logic            rst_n,
  input  logic [PINS-1:0] latch_q,
  input  logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic [PINS-1:0] pin_pu
);
  genvar g;
  generate
    for (g = 0; g < PINS; g++) begin : g_pad
      logic drive;
      assign drive      = dir_q[g] & rst_n;
      assign pin_oe[g]  = drive;
      assign pin_out[g] = drive & latch_q[g];
      assign pin_pu[g]  = ~dir_q[g] & latch_q[g];
    end
  endgenerate
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int                PINS       = GPIO_PINS,
  parameter int                ADDR_W     = GPIO_ADDR_W,
  parameter int                DATA_W     = GPIO_DATA_W,
  parameter int                SYNC_DEPTH = GPIO_SYNC_DEPTH,
  parameter logic [ADDR_W-1:0] PIN_ADDR   = GPIO_PIN_ADDR,
  parameter logic [ADDR_W-1:0] DIR_ADDR   = GPIO_DIR_ADDR,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = GPIO_LATCH_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_we,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   pin_pu,
  input  logic [PINS-1:0]   pin_in
);
  logic            rst_sync_n;
  gpio_sel_e       sel;
  logic [PINS-1:0] latch_q;
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] pin_sync;

  generate
    if (PINS < DATA_W) begin : g_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^io_wdata[DATA_W-1:PINS];
    end
  endgenerate

  gpio_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_addr_dec #(
    .ADDR_W     (ADDR_W),
    .PIN_ADDR   (PIN_ADDR),
    .DIR_ADDR   (DIR_ADDR),
    .LATCH_ADDR (LATCH_ADDR)
  ) u_dec (
    .addr (io_addr),
    .sel  (sel)
  );

  gpio_regs #(.PINS(PINS)) u_regs (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .we         (io_we),
    .sel        (sel),
    .wdata      (io_wdata[PINS-1:0]),
    .latch_q    (latch_q),
    .dir_q      (dir_q)
  );

  gpio_in_sync #(.PINS(PINS), .STAGES(SYNC_DEPTH)) u_in_sync (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .pin_raw    (pin_in),
    .pin_sync   (pin_sync)
  );

  gpio_pad_ctrl #(.PINS(PINS)) u_pad (
    .rst_n   (rst_n),
    .latch_q (latch_q),
    .dir_q   (dir_q),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .pin_pu  (pin_pu)
  );

  always_comb begin
    unique case (sel)
      SEL_LATCH: io_rdata = DATA_W'(latch_q);
      SEL_DIR:   io_rdata = DATA_W'(dir_q);
      SEL_PIN:   io_rdata = DATA_W'(pin_sync);
      default:   io_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int PINS       = 7,
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 8,
  parameter int SYNC_DEPTH = 2,
  parameter logic [ADDR_W-1:0] PIN_ADDR   = 6'h10,
  parameter logic [ADDR_W-1:0] DIR_ADDR   = 6'h11,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 6'h12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_we,
  input logic [DATA_W-1:0] io_wdata,
  input logic [PINS-1:0]   pin_oe,
  input logic [PINS-1:0]   pin_pu,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_in,
  input logic [PINS-1:0]   pin_sync,
  input logic [PINS-1:0]   latch_q,
  input logic [PINS-1:0]   dir_q
);
  logic [2:0] live_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           live_cnt <= '0;
    else if (rst_sync_n && live_cnt != 3'd7) live_cnt <= live_cnt + 3'd1;
  end

  a_r2_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_addr == LATCH_ADDR && rst_sync_n) |=> (latch_q == $past(io_wdata[PINS-1:0])));

  a_r3_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_addr == DIR_ADDR && rst_sync_n) |=> (dir_q == $past(io_wdata[PINS-1:0])));

  a_r4_pin_addr_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_addr == PIN_ADDR && live_cnt > 3'd1) |=> ($stable(latch_q) && $stable(dir_q)));

  a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_addr != PIN_ADDR && io_addr != DIR_ADDR && io_addr != LATCH_ADDR && live_cnt > 3'd1)
    |=> ($stable(latch_q) && $stable(dir_q)));

  a_r5_no_pullup_on_output: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & pin_pu) == '0);

  a_r6_pullup_rule: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pu == (~pin_oe & latch_q));

  a_r6_no_drive_when_input: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  generate
    if (SYNC_DEPTH == 2) begin : g_lag
      a_r7_pin_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt > 3'd4) |-> (pin_sync == $past(pin_in, 2)));
    end
  endgenerate
endmodule

bind gpio_port gpio_port_chk #(
  .PINS       (PINS),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .SYNC_DEPTH (SYNC_DEPTH),
  .PIN_ADDR   (PIN_ADDR),
  .DIR_ADDR   (DIR_ADDR),
  .LATCH_ADDR (LATCH_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .io_addr    (io_addr),
  .io_we      (io_we),
  .io_wdata   (io_wdata),
  .pin_oe     (pin_oe),
  .pin_pu     (pin_pu),
  .pin_out    (pin_out),
  .pin_in     (pin_in),
  .pin_sync   (pin_sync),
  .latch_q    (latch_q),
  .dir_q      (dir_q)
);

// File: tb/gpio_port_test.sv
module gpio_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [5:0] io_addr = '0;
  logic       io_we = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic [6:0] pin_out, pin_oe, pin_pu, pin_in;
  logic [6:0] ext_en = '0;
  logic [6:0] ext_val = '0;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // pad: own driver wins, else external source, else pull-up, else reads low
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_en & ext_val)
                | (~pin_oe & ~ext_en & pin_pu);

  gpio_port uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_we(io_we),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_pu(pin_pu), .pin_in(pin_in)
  );

  typedef struct packed {
    logic       we;
    logic [5:0] waddr;
    logic [7:0] wdata;
    logic [5:0] raddr;
    logic [7:0] rd;
    logic [6:0] oe;
    logic [6:0] pu;
    logic [6:0] out;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 6'h12, 8'hFF, 6'h12, 8'h7F, 7'h00, 7'h7F, 7'h00}, // R2 bit7 dropped, R6
    '{1'b1, 6'h11, 8'h0F, 6'h11, 8'h0F, 7'h0F, 7'h70, 7'h0F}, // R3 R5 R6
    '{1'b1, 6'h10, 8'h00, 6'h12, 8'h7F, 7'h0F, 7'h70, 7'h0F}, // R4
    '{1'b1, 6'h10, 8'h55, 6'h11, 8'h0F, 7'h0F, 7'h70, 7'h0F}, // R4
    '{1'b1, 6'h13, 8'hAA, 6'h12, 8'h7F, 7'h0F, 7'h70, 7'h0F}, // R8
    '{1'b0, 6'h00, 8'h00, 6'h13, 8'h00, 7'h0F, 7'h70, 7'h0F}, // R8
    '{1'b1, 6'h12, 8'h2A, 6'h12, 8'h2A, 7'h0F, 7'h20, 7'h0A}, // R5 R6
    '{1'b1, 6'h11, 8'hF0, 6'h11, 8'h70, 7'h70, 7'h0A, 7'h20}, // R3 R5 R6
    '{1'b1, 6'h12, 8'h80, 6'h12, 8'h00, 7'h70, 7'h00, 7'h00}, // R2 R6
    '{1'b1, 6'h11, 8'h7F, 6'h3F, 8'h00, 7'h7F, 7'h00, 7'h00}, // R8 R5
    '{1'b1, 6'h12, 8'h55, 6'h12, 8'h55, 7'h7F, 7'h00, 7'h55}, // R5
    '{1'b1, 6'h11, 8'h00, 6'h11, 8'h00, 7'h00, 7'h55, 7'h00}, // R6
    '{1'b1, 6'h00, 8'hFF, 6'h11, 8'h00, 7'h00, 7'h55, 7'h00}  // R8
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_we = 1'b1;
    @(posedge clk);
    #1 io_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    #2;
    io_addr = 6'h12;
    #1 check("R1 latch in reset", io_rdata, 8'h00);
    check("R1 oe in reset", {1'b0, pin_oe}, 8'h00);
    check("R1 pu in reset", {1'b0, pin_pu}, 8'h00);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 io_addr = 6'h11;
    #1 check("R1 dir after release", io_rdata, 8'h00);
    check("R1 out after release", {1'b0, pin_out}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      io_addr = VEC[i].waddr; io_wdata = VEC[i].wdata; io_we = VEC[i].we;
      @(posedge clk);
      #1 io_we = 1'b0; io_addr = VEC[i].raddr;
      #1;
      check("R2/R3/R4/R8 vector readback", io_rdata, VEC[i].rd);
      check("R5/R6 vector oe", {1'b0, pin_oe}, {1'b0, VEC[i].oe});
      check("R5/R6 vector pu", {1'b0, pin_pu}, {1'b0, VEC[i].pu});
      check("R5/R6 vector out", {1'b0, pin_out}, {1'b0, VEC[i].out});
    end

    // pulled-up floating inputs read high through the synchronizer (latch 0x55, all inputs)
    repeat (3) @(posedge clk);
    #1 io_addr = 6'h10;
    #1 check("R7 pull-up level read", io_rdata, 8'h55);

    // external drive: two-edge lag
    @(negedge clk) begin ext_en = 7'h7F; ext_val = 7'h0A; end
    @(posedge clk); #1;
    check("R7 one edge still old", io_rdata, 8'h55);
    @(posedge clk); #1;
    check("R7 two edges new value", io_rdata, 8'h0A);
    io_addr = 6'h12;
    #1 check("R10 same-cycle address switch", io_rdata, 8'h55);

    // output mode drives the pad
    @(negedge clk) ext_en = 7'h00;
    bus_write(6'h12, 8'h33);
    bus_write(6'h11, 8'hFF);
    repeat (3) @(posedge clk);
    #1 io_addr = 6'h10;
    #1 check("R5 driven value reaches pin", io_rdata, 8'h33);

    // asynchronous reset between edges
    @(posedge clk);
    #2 rst_n = 1'b0;
    #1 check("R9 oe cleared without clock", {1'b0, pin_oe}, 8'h00);
    check("R9 out cleared without clock", {1'b0, pin_out}, 8'h00);
    io_addr = 6'h12;
    #1 check("R1 latch cleared by reset", io_rdata, 8'h00);
    io_addr = 6'h11;
    #1 check("R1 dir cleared by reset", io_rdata, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    bus_write(6'h12, 8'h01);
    io_addr = 6'h12;
    #1 check("R2 write after reset release", io_rdata, 8'h01);
    check("R6 pull-up after reset release", {1'b0, pin_pu}, 8'h01);

    finish_run();
  end
endmodule